// File: doc/BRIEF.md
# Sequenced Key Loader with CRC-8

This block holds the 128-bit key of one protected memory region. Software supplies the key as four 32-bit words. The block stores every accepted word at once. It also follows the order in which the words arrive. When the words come in as index 0, 1, 2 and then 3, it publishes an 8-bit CRC of the whole key. Any other order leaves the CRC at zero.

The region configuration logic and the access logic use two results. The CRC is the check value, and the key-valid flag is high whenever that CRC is nonzero. A key lock or a config lock from the region's configuration freezes the stored key and the CRC. A mode-change pulse erases both, unless a lock is set. The cipher itself sits in a different block and receives the assembled key on a wide output.

Top module: `keyseq_loader`

## Requirements
- R1: An accepted write of index n (values 0 to 3) places its 32-bit data at key bits 32n+31 down to 32n on the first clock edge. This holds whether or not the write is in sequence.
- R2: A nonzero CRC appears only on the edge that accepts index 3 as the fourth write of an unbroken in-order run 0, 1, 2, 3.
- R3: An accepted write of index 0 always begins a new run. From the next edge the CRC reads zero, and it stays zero while that run is incomplete.
- R4: An accepted write whose index is neither 0 nor the next index the run expects aborts the run. This includes a repeated index and any write while no run is open. The CRC becomes zero, and only a fresh index-0 write can reopen a run.
- R5: The CRC register starts at 0x00 and uses polynomial 0x07 (x^8+x^2+x+1), with no reflection and no final XOR. It is fed 128 bits: word 0 first and word 3 last, each word most significant bit first.
- R6: While keyLock or cfgLock is high, key writes are discarded. The key output and the CRC stay unchanged.
- R7: While keyLock or cfgLock is high, a mode-change pulse has no effect, and the CRC stays frozen.
- R8: With both locks low, a mode-change pulse clears the key, clears the CRC and closes any open run on the next edge. It takes priority over a write in the same cycle.
- R9: keyValid is high exactly when the CRC is nonzero. An all-zero key loaded in order gives CRC 0x00, so keyValid stays low.
- R10: An active-low reset, applied asynchronously, clears the key, the CRC and the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Key word write strobe |
| wrIdx | input | 2 | Index of the key word being written (0 to 3) |
| wrData | input | 32 | Key word data |
| keyLock | input | 1 | Region key lock level |
| cfgLock | input | 1 | Region config lock level |
| modeChange | input | 1 | Pulse: the region mode was changed |
| keyOut | output | 128 | Assembled key toward the cipher core |
| keyCrc | output | 8 | CRC of the last complete in-order key load, else zero |
| keyValid | output | 1 | High when keyCrc is nonzero |

## Verification
Each registered result (the key output, the CRC and the flag that follows it) is due on the first rising edge after the strobe that causes it. The bench therefore drives every stimulus on a falling edge and compares the outputs 1 ns after the next rising edge, against a reference model that it updates at that same point. Reset is the one result that does not wait for an edge: the bench checks it 1 ns after rstN falls, with no clock edge in between.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;
  localparam int KS_WORDS = 4;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic [KS_WORDS-1:0] storeWord;  // one-hot: capture wrData into this word
    logic                accStart;   // seed running CRC from zero with wrData
    logic                accStep;    // fold wrData into running CRC
    logic                crcCommit;  // publish running CRC folded with wrData
    logic                crcClear;   // force published CRC to zero
    logic                wipe;       // erase key, running and published CRC
  } ksStrobe_t;
endpackage

// File: rtl/keyseq_ctrl.sv
module keyseq_ctrl import keyseq_pkg::*; #(
  parameter int NUM_WORDS = KS_WORDS,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             keyLock,
  input  logic             cfgLock,
  input  logic             modeChange,
  output ksStrobe_t        strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic             armed;
  logic [IDX_W-1:0] expIdx;
  logic             locked;
  logic             take;
  logic             inOrder;
  logic             isStart;

  assign locked  = keyLock | cfgLock;
  assign take    = wrEn & ~locked & ~modeChange;
  assign isStart = (wrIdx == '0);
  assign inOrder = armed & (wrIdx == expIdx);

  always_comb begin
    strobe = '0;
    if (!locked && modeChange) strobe.wipe = 1'b1;
    if (take) begin
      strobe.storeWord = KS_WORDS'(1) << wrIdx;
      if (isStart) begin
        strobe.accStart = 1'b1;
        strobe.crcClear = 1'b1;
      end else if (inOrder && wrIdx == LAST_IDX) begin
        strobe.crcCommit = 1'b1;
      end else if (inOrder) begin
        strobe.accStep  = 1'b1;
        strobe.crcClear = 1'b1;
      end else begin
        strobe.crcClear = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      expIdx <= '0;
    end else if (strobe.wipe) begin
      armed  <= 1'b0;
      expIdx <= '0;
    end else if (take) begin
      if (isStart) begin
        armed  <= 1'b1;
        expIdx <= IDX_W'(1);
      end else if (inOrder && wrIdx != LAST_IDX) begin
        expIdx <= expIdx + IDX_W'(1);
      end else begin
        armed  <= 1'b0;
      end
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (take && isStart) |=> (armed && expIdx == IDX_W'(1))); // R3

  AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (take && !isStart && !inOrder) |=> !armed); // R4

  AST_WIPE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (modeChange && !keyLock && !cfgLock) |=> !armed); // R8
endmodule

// File: rtl/keyseq_dp.sv
module keyseq_dp import keyseq_pkg::*; #(
  parameter int              WORD_W    = 32,
  parameter int              NUM_WORDS = KS_WORDS,
  parameter int              CRC_W     = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter int              KEY_W     = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ksStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [KEY_W-1:0]  keyOut,
  output logic [CRC_W-1:0]  crcOut
);
  logic [CRC_W-1:0] accQ;
  logic [CRC_W-1:0] crcQ;

  function automatic logic [CRC_W-1:0] crcFold(input logic [CRC_W-1:0] seed,
                                               input logic [WORD_W-1:0] data);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = seed;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  wordQ <= '0;
      else if (strobe.wipe)       wordQ <= '0;
      else if (strobe.storeWord[w]) wordQ <= wrData;
    end
    assign keyOut[w*WORD_W +: WORD_W] = wordQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                accQ <= '0;
    else if (strobe.wipe)     accQ <= '0;
    else if (strobe.accStart) accQ <= crcFold('0, wrData);
    else if (strobe.accStep)  accQ <= crcFold(accQ, wrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 crcQ <= '0;
    else if (strobe.wipe)      crcQ <= '0;
    else if (strobe.crcCommit) crcQ <= crcFold(accQ, wrData);
    else if (strobe.crcClear)  crcQ <= '0;
  end

  assign crcOut = crcQ;

  AST_CRC_SET_BY_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ((crcQ != '0) && (crcQ != $past(crcQ))) |-> $past(strobe.crcCommit)); // R2

  AST_CLEAR_ZEROES_CRC: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.crcClear || strobe.wipe) |=> (crcQ == '0)); // R3
endmodule

// File: rtl/keyseq_loader.sv
module keyseq_loader import keyseq_pkg::*; #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = KS_WORDS,
  parameter int CRC_W     = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS),
  parameter int KEY_W     = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic              keyLock,
  input  logic              cfgLock,
  input  logic              modeChange,
  output logic [KEY_W-1:0]  keyOut,
  output logic [CRC_W-1:0]  keyCrc,
  output logic              keyValid
);
  ksStrobe_t strobe;

  keyseq_ctrl #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx),
    .keyLock(keyLock), .cfgLock(cfgLock), .modeChange(modeChange),
    .strobe(strobe)
  );

  keyseq_dp #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CRC_W(CRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .keyOut(keyOut), .crcOut(keyCrc)
  );

  assign keyValid = |keyCrc;

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (keyLock || cfgLock) |=> ($stable(keyCrc) && $stable(keyOut))); // R6

  AST_MODE_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    (modeChange && !keyLock && !cfgLock) |=> (keyOut == '0 && keyCrc == '0)); // R8

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyValid) |-> $past(wrEn && wrIdx == IDX_W'(NUM_WORDS - 1) &&
                              !keyLock && !cfgLock && !modeChange)); // R2
endmodule

// File: tb/sim_keyseq_loader.sv
module sim_keyseq_loader;
  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [1:0]   wrIdx;
  logic [31:0]  wrData;
  logic         keyLock;
  logic         cfgLock;
  logic         modeChange;
  logic [127:0] keyOut;
  logic [7:0]   keyCrc;
  logic         keyValid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  keyseq_loader u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .keyLock(keyLock), .cfgLock(cfgLock), .modeChange(modeChange),
    .keyOut(keyOut), .keyCrc(keyCrc), .keyValid(keyValid)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        mc;
    logic        kl;
    logic        cl;
    logic        we;
    logic [1:0]  idx;
    logic [31:0] data;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0123_4567,4'd3}, // R3 start
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h89AB_CDEF,4'd2}, // R2 no CRC yet
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'hFEDC_BA98,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h7654_3210,4'd5}, // R5 complete
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0BAD_F00D,4'd4}, // R4 repeat
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'hDEAD_BEEF,4'd3},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'hCAFE_0001,4'd4}, // R4 skip
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h1234_0000,4'd4}, // R4 not open
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0000_0001,4'd3},
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h0000_0002,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'hA5A5_5A5A,4'd3}, // R3 restart
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'hFFFF_FFFF,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'h8000_0000,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_0080,4'd5}, // R5
    '{1'b0,1'b0,1'b0,1'b0,2'd0,32'h0000_0000,4'd1}, // R1 idle hold
    '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0000_0000,4'd8}, // R8 wipe
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0000_0000,4'd9}, // R9 zero key
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h0000_0000,4'd9},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'h0000_0000,4'd9},
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_0000,4'd9},
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0000_0001,4'd1}, // R1
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h0000_0002,4'd1},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'h0000_0003,4'd1},
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_0004,4'd5},
    '{1'b1,1'b0,1'b0,1'b1,2'd0,32'h5555_5555,4'd8}, // R8 wins over write
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h1111_1111,4'd3},
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h2222_2222,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'h3333_3333,4'd2},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0000_0000,4'd8}, // R8 closes run
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h4444_4444,4'd4}, // R4 after wipe
    '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h1357_9BDF,4'd3},
    '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h2468_ACE0,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,32'hF0F0_0F0F,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h3C3C_C3C3,4'd5},
    '{1'b0,1'b1,1'b0,1'b1,2'd0,32'h9999_9999,4'd6}, // R6 key lock
    '{1'b1,1'b1,1'b0,1'b0,2'd0,32'h0000_0000,4'd7}, // R7
    '{1'b0,1'b0,1'b1,1'b1,2'd3,32'h7777_7777,4'd6}, // R6 config lock
    '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0000_0000,4'd7}  // R7
  };

  // Reference model
  logic [31:0] mWord [4];
  logic [7:0]  mAcc;
  logic [7:0]  mCrc;
  int          mNext;  // -1 means no run open

  function automatic logic [7:0] refCrc(input logic [7:0] s, input logic [31:0] d);
    logic [7:0] c = s;
    for (int b = 31; b >= 0; b--) begin
      if (c[7] ^ d[b]) c = (c << 1) ^ 8'h07;
      else             c = c << 1;
    end
    return c;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 4; k++) mWord[k] = '0;
    mAcc = '0; mCrc = '0; mNext = -1;
  endtask

  task automatic modelStep(input vec_t v);
    if (v.kl || v.cl) return;
    if (v.mc) begin
      modelReset();
      return;
    end
    if (!v.we) return;
    mWord[v.idx] = v.data;
    if (v.idx == 2'd0) begin
      mAcc = refCrc(8'h00, v.data); mNext = 1; mCrc = '0;
    end else if (mNext == int'(v.idx)) begin
      if (v.idx == 2'd3) begin
        mCrc = refCrc(mAcc, v.data); mNext = -1;
      end else begin
        mAcc = refCrc(mAcc, v.data); mNext++; mCrc = '0;
      end
    end else begin
      mNext = -1; mCrc = '0;
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "key", keyOut, {mWord[3], mWord[2], mWord[1], mWord[0]});
    check(req, "crc", {120'd0, keyCrc}, {120'd0, mCrc});
    check("R9", "valid", {127'd0, keyValid}, {127'd0, (mCrc != 8'h00)});
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    modeChange = v.mc; keyLock = v.kl; cfgLock = v.cl;
    wrEn = v.we; wrIdx = v.idx; wrData = v.data;
    @(posedge clk);
    #1;
    modelStep(v);
  endtask

  task automatic idle();
    @(negedge clk);
    modeChange = 0; keyLock = 0; cfgLock = 0; wrEn = 0; wrIdx = 0; wrData = 0;
  endtask

  initial begin
    #(100_000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; wrIdx = 0; wrData = 0;
    keyLock = 0; cfgLock = 0; modeChange = 0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    checkAll("R10");  // reset state
    @(negedge clk);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i]);
      checkAll($sformatf("R%0d", VEC[i].tag));
    end
    idle();

    // R10: asynchronous reset in the middle of a run
    step('{1'b0,1'b0,1'b0,1'b1,2'd0,32'hABCD_0000,4'd3});
    step('{1'b0,1'b0,1'b0,1'b1,2'd1,32'hABCD_0001,4'd2});
    step('{1'b0,1'b0,1'b0,1'b1,2'd2,32'hABCD_0002,4'd2});
    step('{1'b0,1'b0,1'b0,1'b1,2'd3,32'hABCD_0003,4'd5});
    checkAll("R5");
    step('{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0F0F_0000,4'd3});
    step('{1'b0,1'b0,1'b0,1'b1,2'd1,32'h0F0F_0001,4'd2});
    idle();
    #2;
    rstN = 0;
    #1;
    modelReset();
    checkAll("R10");  // cleared without a clock edge
    @(negedge clk);
    rstN = 1;
    // run state cleared by reset: words 2 and 3 alone must not produce a CRC
    step('{1'b0,1'b0,1'b0,1'b1,2'd2,32'h0F0F_0002,4'd4});
    step('{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0F0F_0003,4'd4});
    checkAll("R10");
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule